// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Channel

This block is one asynchronous serial channel. It contains an 8-bit control register, a receiver, a transmitter and a fixed-rate baud tick. The receiver oversamples the line at 16 ticks per bit and takes the value at the middle of each bit. A frame is one low start bit, eight data bits sent LSB first, an optional parity bit, an optional address bit and one high stop bit. The transmitter sends the same frame layout from a one-byte hold register.

When the channel runs in multiprocessor format, every frame carries the extra address bit. A wake-up enable in the control register can then gate received frames. Only frames with the address bit set reach the receive-full flag, the data register and the four error flags (overrun, framing, parity, break). All other frames are dropped without leaving a trace. Software clears every error flag in one step by writing the control register with bit 3 at zero. In multiprocessor format, reading bit 3 returns the address bit of the last accepted frame.

Top module: `mpSerialChan`

## Requirements
- R1: After reset, the control register reads 0x08 when multiprocessor format is off and 0x00 when it is on. `rtsOut` is 0, `txOut` is 1, `txEmpty` is 1, and `rxFull` and all four error flags are 0.
- R2: The control register layout is: bit 7 wake-up enable, bit 6 receiver enable, bit 5 transmitter enable, bit 4 RTS, bits 2..0 format. Format bit 1 enables parity. Format bit 0 selects odd parity (0 selects even). Format bit 2 is stored only. Written values read back on `ctrlRd` one cycle after the write. Bit 3 reads 1 whenever `mpMode` is 0.
- R3: `rtsOut` follows bit 4 of the most recent control write. Changing it alters no other register bit and no flag.
- R4: A received frame with a high stop bit loads its data byte into `rxData` and sets `rxFull`. A pulse on `rxRead` clears `rxFull`.
- R5: A frame accepted while `rxFull` is still set raises `errOvr` and leaves `rxData` unchanged.
- R6: A low stop bit raises `errFrm`. A frame that is low in every bit, stop bit included, raises both `errBrk` and `errFrm`.
- R7: With parity enabled, a parity bit that does not give the selected parity over the data byte raises `errPar`. A correct parity bit leaves `errPar` at 0.
- R8: A control write with bit 3 at 0 clears all four error flags together. A control write with bit 3 at 1 leaves them unchanged.
- R9: With `mpMode` at 1 and wake-up enabled, a frame whose address bit (the bit after the parity bit, or after the data when parity is off) is 0 changes neither `rxFull`, `rxData` nor any error flag.
- R10: With wake-up disabled, or with `mpMode` at 0, every frame is accepted whatever its address bit.
- R11: With `mpMode` at 1, control bit 3 reads the address bit of the last accepted frame.
- R12: A byte written through `txWrEn` goes out as start 0, data LSB first and stop 1, each bit 16 baud ticks long. `txEmpty` falls on the write and rises when the transmitter takes the byte.
- R13: Clearing the transmitter enable stops a frame in progress and forces `txOut` high. `txEmpty` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mpMode | input | 1 | Selects multiprocessor frame format (adds the address bit) |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| ctrlRd | output | 8 | Control register read value |
| rtsOut | output | 1 | Request-to-send pin |
| rxIn | input | 1 | Serial receive line, idle high |
| rxRead | input | 1 | Pulse that consumes the received byte |
| rxData | output | 8 | Last accepted received byte |
| rxFull | output | 1 | Receive data register full |
| errOvr | output | 1 | Overrun error flag |
| errFrm | output | 1 | Framing error flag |
| errPar | output | 1 | Parity error flag |
| errBrk | output | 1 | Break flag |
| txWrEn | input | 1 | Transmit hold register write strobe |
| txWrData | input | 8 | Byte to transmit |
| txWrMpb | input | 1 | Address bit sent with the byte in multiprocessor format |
| txEmpty | output | 1 | Transmit hold register empty |
| txOut | output | 1 | Serial transmit line, idle high |

## Verification
Register read-back and `rtsOut` change one clock after a control write. The bench therefore checks them on the falling edge after the write strobe. Receive results appear one clock after the middle sample of the stop bit. That sample comes half a bit plus two synchroniser stages after the stop bit starts, so the bench reads the flags and `rxData` only once it has driven the whole stop bit and some idle time. Transmit bits are due 16 ticks apart, counted from whenever the hold register is loaded. The bench waits for the falling start edge and then samples at the middle of each bit, which absorbs the up-to-one-tick phase offset of the load.

// File: rtl/serPkg.sv
package serPkg;

  // Strobes and mode bits from control to datapath
  typedef struct packed {
    logic rxEn;
    logic txEn;
    logic txStart;
    logic parEn;
    logic parOdd;
    logic mpFmt;
  } ctrlStrb_t;

  // One received frame, valid while done is high
  typedef struct packed {
    logic       done;
    logic [7:0] data;
    logic       mpb;
    logic       parBad;
    logic       stopBad;
    logic       allLow;
  } rxRes_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_RUN,
    RX_DONE,
    RX_WAITHI
  } rxState_t;

endpackage

// File: rtl/serDatapath.sv
module serDatapath
  import serPkg::*;
#(
  parameter int BAUD_DIV   = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrb_t  strb,
  input  logic [7:0] txByte,
  input  logic       txMpb,
  input  logic       rxIn,
  output rxRes_t     rxRes,
  output logic       txBusy,
  output logic       txOut
);

  localparam int DIVW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int OVW  = $clog2(OVERSAMPLE);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(BAUD_DIV - 1);
  localparam logic [OVW-1:0]  OVS_MID  = OVW'(OVERSAMPLE / 2 - 1);
  localparam logic [OVW-1:0]  OVS_LAST = OVW'(OVERSAMPLE - 1);

  // baud tick
  logic [DIVW-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // frame length in bits, start and stop included
  logic [3:0] nBits;
  assign nBits = 4'd10 + {3'b000, strb.parEn} + {3'b000, strb.mpFmt};

  // receiver
  logic rxMeta, rxSync;
  rxState_t rxState;
  logic [OVW-1:0] rxOvs;
  logic [3:0] rxIdx;
  logic [15:0] rxShift;
  logic [15:0] frameMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxOvs   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
    end else if (!strb.rxEn) begin
      rxState <= RX_IDLE;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (tick && !rxSync) begin
            rxState <= RX_RUN;
            rxOvs   <= '0;
            rxIdx   <= '0;
          end
        end
        RX_RUN: begin
          if (tick) begin
            rxOvs <= rxOvs + 1'b1;
            if (rxOvs == OVS_MID) begin
              if (rxIdx == 4'd0 && rxSync) begin
                rxState <= RX_IDLE;          // glitch, not a start bit
              end else begin
                rxShift[rxIdx] <= rxSync;
                if (rxIdx == nBits - 4'd1) rxState <= RX_DONE;
                else                       rxIdx   <= rxIdx + 4'd1;
              end
            end
          end
        end
        RX_DONE:   rxState <= rxSync ? RX_IDLE : RX_WAITHI;
        RX_WAITHI: if (rxSync) rxState <= RX_IDLE;
        default:   rxState <= RX_IDLE;
      endcase
    end
  end

  assign frameMask = (16'd1 << nBits) - 16'd1;

  always_comb begin
    rxRes.done    = (rxState == RX_DONE);
    rxRes.data    = rxShift[8:1];
    rxRes.mpb     = strb.parEn ? rxShift[10] : rxShift[9];
    rxRes.parBad  = strb.parEn && ((^rxShift[9:1]) != strb.parOdd);
    rxRes.stopBad = !rxShift[nBits - 4'd1];
    rxRes.allLow  = ((rxShift & frameMask) == 16'd0);
  end

  // transmitter
  logic [15:0] txFrame, txFrameNext;
  logic [3:0] txIdx, txLen;
  logic [OVW-1:0] txOvs;
  logic txParBit;

  assign txParBit = (^txByte) ^ strb.parOdd;

  always_comb begin
    txFrameNext      = '1;
    txFrameNext[0]   = 1'b0;
    txFrameNext[8:1] = txByte;
    if (strb.parEn) txFrameNext[9] = txParBit;
    if (strb.mpFmt) begin
      if (strb.parEn) txFrameNext[10] = txMpb;
      else            txFrameNext[9]  = txMpb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txOut   <= 1'b1;
      txOvs   <= '0;
      txIdx   <= '0;
      txLen   <= '0;
      txFrame <= '1;
    end else if (!strb.txEn) begin
      txBusy <= 1'b0;
      txOut  <= 1'b1;
    end else if (!txBusy && strb.txStart) begin
      txFrame <= txFrameNext;
      txLen   <= nBits;
      txBusy  <= 1'b1;
      txOut   <= 1'b0;
      txOvs   <= '0;
      txIdx   <= '0;
    end else if (txBusy && tick) begin
      txOvs <= txOvs + 1'b1;
      if (txOvs == OVS_LAST) begin
        if (txIdx == txLen - 4'd1) begin
          txBusy <= 1'b0;
          txOut  <= 1'b1;
        end else begin
          txIdx <= txIdx + 4'd1;
          txOut <= txFrame[txIdx + 4'd1];
        end
      end
    end
  end

endmodule

// File: rtl/serCtrl.sv
module serCtrl
  import serPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mpMode,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       rxRead,
  input  logic       txWrEn,
  input  logic [7:0] txWrData,
  input  logic       txWrMpb,
  input  rxRes_t     rxRes,
  input  logic       txBusy,
  output ctrlStrb_t  strb,
  output logic [7:0] txByte,
  output logic       txMpb,
  output logic [7:0] ctrlRd,
  output logic       rtsOut,
  output logic [7:0] rxData,
  output logic       rxFull,
  output logic       errOvr,
  output logic       errFrm,
  output logic       errPar,
  output logic       errBrk,
  output logic       txEmpty
);

  logic wakeEn, rxEnR, txEnR, rtsR, lastMpb;
  logic [2:0] fmt;
  logic accept, errClr;

  assign accept = rxRes.done && (!(mpMode && wakeEn) || rxRes.mpb);
  assign errClr = regWrEn && !regWrData[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn <= 1'b0;
      rxEnR  <= 1'b0;
      txEnR  <= 1'b0;
      rtsR   <= 1'b0;
      fmt    <= 3'b000;
    end else if (regWrEn) begin
      wakeEn <= regWrData[7];
      rxEnR  <= regWrData[6];
      txEnR  <= regWrData[5];
      rtsR   <= regWrData[4];
      fmt    <= regWrData[2:0];
    end
  end

  assign ctrlRd = {wakeEn, rxEnR, txEnR, rtsR, (mpMode ? lastMpb : 1'b1), fmt};
  assign rtsOut = rtsR;

  // receive data and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxFull  <= 1'b0;
      lastMpb <= 1'b0;
    end else begin
      if (rxRead) rxFull <= 1'b0;
      if (accept) begin
        lastMpb <= rxRes.mpb;
        if (!rxFull) begin
          rxData <= rxRes.data;
          rxFull <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errOvr <= 1'b0;
      errFrm <= 1'b0;
      errPar <= 1'b0;
      errBrk <= 1'b0;
    end else begin
      if (errClr) begin
        errOvr <= 1'b0;
        errFrm <= 1'b0;
        errPar <= 1'b0;
        errBrk <= 1'b0;
      end
      if (accept) begin
        if (rxFull)        errOvr <= 1'b1;
        if (rxRes.stopBad) errFrm <= 1'b1;
        if (rxRes.parBad)  errPar <= 1'b1;
        if (rxRes.allLow)  errBrk <= 1'b1;
      end
    end
  end

  // transmit hold register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte  <= '0;
      txMpb   <= 1'b0;
      txEmpty <= 1'b1;
    end else begin
      if (strb.txStart) txEmpty <= 1'b1;
      if (txWrEn) begin
        txByte  <= txWrData;
        txMpb   <= txWrMpb;
        txEmpty <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.rxEn    = rxEnR;
    strb.txEn    = txEnR;
    strb.txStart = txEnR && !txEmpty && !txBusy;
    strb.parEn   = fmt[1];
    strb.parOdd  = fmt[0];
    strb.mpFmt   = mpMode;
  end

endmodule

// File: rtl/mpSerialChan.sv
module mpSerialChan
  import serPkg::*;
#(
  parameter int BAUD_DIV   = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mpMode,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] ctrlRd,
  output logic       rtsOut,
  input  logic       rxIn,
  input  logic       rxRead,
  output logic [7:0] rxData,
  output logic       rxFull,
  output logic       errOvr,
  output logic       errFrm,
  output logic       errPar,
  output logic       errBrk,
  input  logic       txWrEn,
  input  logic [7:0] txWrData,
  input  logic       txWrMpb,
  output logic       txEmpty,
  output logic       txOut
);

  ctrlStrb_t strb;
  rxRes_t    rxRes;
  logic [7:0] txByte;
  logic txMpb, txBusy;
  logic rxDoneTap, rxMpbTap;

  assign rxDoneTap = rxRes.done;
  assign rxMpbTap  = rxRes.mpb;

  serCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .mpMode(mpMode),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .rxRead(rxRead), .txWrEn(txWrEn), .txWrData(txWrData), .txWrMpb(txWrMpb),
    .rxRes(rxRes), .txBusy(txBusy),
    .strb(strb), .txByte(txByte), .txMpb(txMpb),
    .ctrlRd(ctrlRd), .rtsOut(rtsOut),
    .rxData(rxData), .rxFull(rxFull),
    .errOvr(errOvr), .errFrm(errFrm), .errPar(errPar), .errBrk(errBrk),
    .txEmpty(txEmpty)
  );

  serDatapath #(.BAUD_DIV(BAUD_DIV), .OVERSAMPLE(OVERSAMPLE)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txByte(txByte), .txMpb(txMpb),
    .rxIn(rxIn), .rxRes(rxRes),
    .txBusy(txBusy), .txOut(txOut)
  );

endmodule

// File: rtl/mpSerialChk.sv
module mpSerialChk (
  input logic       clk,
  input logic       rstN,
  input logic       mpMode,
  input logic       regWrEn,
  input logic       wrBit3,
  input logic       wrBit4,
  input logic       wakeBit,
  input logic       txEnBit,
  input logic       rtsOut,
  input logic       rxRead,
  input logic [7:0] rxData,
  input logic       rxFull,
  input logic       errOvr,
  input logic       errFrm,
  input logic       errPar,
  input logic       errBrk,
  input logic       txWrEn,
  input logic       txEmpty,
  input logic       txOut,
  input logic       rxDone,
  input logic       rxMpb
);

  AST_RTS_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (rtsOut == $past(wrBit4))); // R3

  AST_TX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !txEnBit |=> txOut); // R13

  AST_TXEMPTY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnBit && !txWrEn) |=> $stable(txEmpty)); // R13

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !wrBit3 && !rxDone) |=> !(errOvr || errFrm || errPar || errBrk)); // R8

  AST_WAKE_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && mpMode && wakeBit && !rxMpb && !rxRead && !regWrEn)
      |=> ($stable(rxFull) && $stable(rxData) && $stable({errOvr, errFrm, errPar, errBrk}))); // R9

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxFull && !(mpMode && wakeBit && !rxMpb)) |=> errOvr); // R5

endmodule

bind mpSerialChan mpSerialChk chk_i (
  .clk(clk), .rstN(rstN), .mpMode(mpMode),
  .regWrEn(regWrEn), .wrBit3(regWrData[3]), .wrBit4(regWrData[4]),
  .wakeBit(ctrlRd[7]), .txEnBit(ctrlRd[5]), .rtsOut(rtsOut),
  .rxRead(rxRead), .rxData(rxData), .rxFull(rxFull),
  .errOvr(errOvr), .errFrm(errFrm), .errPar(errPar), .errBrk(errBrk),
  .txWrEn(txWrEn), .txEmpty(txEmpty), .txOut(txOut),
  .rxDone(rxDoneTap), .rxMpb(rxMpbTap)
);

// File: tb/mpSerialChan_tb_top.sv
module mpSerialChan_tb_top;

  localparam int BIT_CLKS = 64;  // 16 ticks of 4 clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mpMode = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] ctrlRd;
  logic rtsOut;
  logic rxIn = 1'b1;
  logic rxRead = 1'b0;
  logic [7:0] rxData;
  logic rxFull, errOvr, errFrm, errPar, errBrk;
  logic txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic txWrMpb = 1'b0;
  logic txEmpty, txOut;

  int checkCnt = 0;
  int errCnt = 0;
  logic [7:0] ctrlVal = 8'h08;

  always #5 clk = ~clk;

  mpSerialChan dut_i (
    .clk(clk), .rstN(rstN), .mpMode(mpMode),
    .regWrEn(regWrEn), .regWrData(regWrData), .ctrlRd(ctrlRd), .rtsOut(rtsOut),
    .rxIn(rxIn), .rxRead(rxRead), .rxData(rxData), .rxFull(rxFull),
    .errOvr(errOvr), .errFrm(errFrm), .errPar(errPar), .errBrk(errBrk),
    .txWrEn(txWrEn), .txWrData(txWrData), .txWrMpb(txWrMpb),
    .txEmpty(txEmpty), .txOut(txOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    if (v[3]) ctrlVal = v;
    else      ctrlVal = v | 8'h08;
  endtask

  task automatic readRx();
    @(negedge clk);
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic withMp, input logic mpb,
                           input logic badPar, input logic stopVal);
    logic parBit;
    parBit = (^d) ^ ctrlVal[0] ^ badPar;
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      rxIn = d[b];
      repeat (BIT_CLKS) @(negedge clk);
    end
    if (ctrlVal[1]) begin
      rxIn = parBit;
      repeat (BIT_CLKS) @(negedge clk);
    end
    if (withMp) begin
      rxIn = mpb;
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxIn = stopVal;
    repeat (BIT_CLKS) @(negedge clk);
    rxIn = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic errVec(output logic [15:0] v);
    v = {12'h000, errOvr, errFrm, errPar, errBrk};
  endtask

  task automatic testReset();
    logic [15:0] ev;
    chk("R1 ctrlRd reset", {8'h00, ctrlRd}, 16'h0008);
    chk("R1 rtsOut reset", {15'h0, rtsOut}, 16'h0000);
    chk("R1 txOut reset", {15'h0, txOut}, 16'h0001);
    chk("R1 txEmpty reset", {15'h0, txEmpty}, 16'h0001);
    chk("R1 rxFull reset", {15'h0, rxFull}, 16'h0000);
    errVec(ev);
    chk("R1 errors reset", ev, 16'h0000);
    mpMode = 1'b1;
    @(negedge clk);
    chk("R1 R11 ctrlRd reset mp format", {8'h00, ctrlRd}, 16'h0000);
    mpMode = 1'b0;
    @(negedge clk);
  endtask

  task automatic testRegRts();
    logic [15:0] ev;
    wrCtrl(8'h78);
    chk("R2 ctrlRd readback", {8'h00, ctrlRd}, 16'h0078);
    chk("R3 rtsOut high", {15'h0, rtsOut}, 16'h0001);
    wrCtrl(8'h6D);
    chk("R2 format bits readback", {8'h00, ctrlRd}, 16'h006D);
    wrCtrl(8'h68);
    chk("R3 rtsOut low", {15'h0, rtsOut}, 16'h0000);
    chk("R3 ctrlRd other bits", {8'h00, ctrlRd}, 16'h0068);
    errVec(ev);
    chk("R3 no flag side effect", {ev[3:0], 2'b00, txEmpty, rxFull, 8'h00}, 16'h0200);
  endtask

  task automatic testRxBasic();
    logic [15:0] ev;
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 rxFull set", {15'h0, rxFull}, 16'h0001);
    chk("R4 rxData", {8'h00, rxData}, 16'h00A5);
    errVec(ev);
    chk("R4 no errors", ev, 16'h0000);
    readRx();
    chk("R4 read clears rxFull", {15'h0, rxFull}, 16'h0000);
  endtask

  task automatic testOverrunClear();
    logic [15:0] ev;
    sendFrame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    sendFrame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 errOvr set", {15'h0, errOvr}, 16'h0001);
    chk("R5 rxData kept", {8'h00, rxData}, 16'h003C);
    readRx();
    wrCtrl(8'h68);
    chk("R8 bit3 one keeps errOvr", {15'h0, errOvr}, 16'h0001);
    wrCtrl(8'h60);
    errVec(ev);
    chk("R8 bit3 zero clears errors", ev, 16'h0000);
  endtask

  task automatic testFrameBreak();
    sendFrame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 framing flags", {14'h0, errFrm, errBrk}, 16'h0002);
    chk("R6 data with bad stop", {8'h00, rxData}, 16'h0055);
    readRx();
    wrCtrl(8'h60);
    sendFrame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 break flags", {14'h0, errFrm, errBrk}, 16'h0003);
    chk("R6 break data", {8'h00, rxData}, 16'h0000);
    readRx();
    wrCtrl(8'h60);
  endtask

  task automatic testParity();
    wrCtrl(8'h6A);
    sendFrame(8'h07, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 good even parity", {15'h0, errPar}, 16'h0000);
    readRx();
    sendFrame(8'h07, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 bad even parity", {15'h0, errPar}, 16'h0001);
    readRx();
    wrCtrl(8'h63);
    sendFrame(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 good odd parity", {15'h0, errPar}, 16'h0000);
    readRx();
    wrCtrl(8'h68);
  endtask

  task automatic testWake();
    logic [15:0] ev;
    mpMode = 1'b1;
    wrCtrl(8'hE8);
    sendFrame(8'h11, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9 address frame accepted", {7'h0, rxFull, rxData}, 16'h0111);
    chk("R11 bit3 reads one", {15'h0, ctrlRd[3]}, 16'h0001);
    readRx();
    sendFrame(8'h22, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 filtered frame leaves data", {7'h0, rxFull, rxData}, 16'h0011);
    errVec(ev);
    chk("R9 filtered frame leaves errors", ev, 16'h0000);
    wrCtrl(8'h68);
    sendFrame(8'h33, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R10 wake off accepts", {7'h0, rxFull, rxData}, 16'h0133);
    chk("R11 bit3 reads zero", {15'h0, ctrlRd[3]}, 16'h0000);
    readRx();
    mpMode = 1'b0;
    wrCtrl(8'hE8);
    sendFrame(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 mp format off accepts", {7'h0, rxFull, rxData}, 16'h0144);
    readRx();
    wrCtrl(8'h68);
  endtask

  task automatic sendTx(input logic [7:0] d);
    @(negedge clk);
    txWrEn = 1'b1;
    txWrData = d;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic testTx();
    logic [9:0] cap;
    sendTx(8'h96);
    repeat (3) @(negedge clk);
    chk("R12 txEmpty after load", {15'h0, txEmpty}, 16'h0001);
    for (int i = 0; i < 200 && txOut; i++) @(negedge clk);
    repeat (BIT_CLKS / 2) @(negedge clk);
    cap[0] = txOut;
    for (int b = 1; b < 10; b++) begin
      repeat (BIT_CLKS) @(negedge clk);
      cap[b] = txOut;
    end
    chk("R12 tx frame bits", {6'h0, cap}, {6'h0, 1'b1, 8'h96, 1'b0});
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic testAbort();
    sendTx(8'h00);
    for (int i = 0; i < 200 && txOut; i++) @(negedge clk);
    repeat (100) @(negedge clk);
    sendTx(8'h5A);
    chk("R12 txEmpty low while busy", {15'h0, txEmpty}, 16'h0000);
    wrCtrl(8'h48);
    repeat (2) @(negedge clk);
    chk("R13 txOut high after abort", {15'h0, txOut}, 16'h0001);
    chk("R13 txEmpty held", {15'h0, txEmpty}, 16'h0000);
    repeat (200) @(negedge clk);
    chk("R13 line stays idle", {14'h0, txOut, txEmpty}, 16'h0002);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testRegRts();
    testRxBasic();
    testOverrunClear();
    testFrameBreak();
    testParity();
    testWake();
    testTx();
    testAbort();
    $display("CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    errCnt++;
    $display("FAIL watchdog R1..R13 run actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  end

endmodule